// File: doc/BRIEF.md
# Clap Event Counter

This block watches a stream of signed audio samples and counts short, loud sound events such as hand claps or finger snaps. Each new sample is converted to its magnitude and fed into a 32-deep running average. That average is compared with two levels. The loud level is programmable; the quiet level is fixed at 64. A three-state controller sees the average rise above the loud level, lets a duration timer run, and stops the timer once the average falls below the quiet level. It then judges whether the event was short enough to count as a clap.

The duration timer does not run on the system clock. It advances once per rising edge of a slow external tick of about 10 Hz, which is synchronised inside the block. An event qualifies when it lasts at most a few such ticks. Each qualifying event adds one to a 15-bit count and inverts a toggle bit. Software detects new events by comparing the toggle bit with its previous value, so it never has to clear a flag.

A processor write sets the loud level and can suspend detection. A read word always presents the count and the toggle bit.

Top module: `clap_event_counter`

## Requirements
- R1: After reset the read word is 0, the loud level is 256 and detection is enabled.
- R2: The read word carries the 15-bit event count in bits 15:1 and the toggle bit in bit 0.
- R3: The detector works on the mean magnitude of the last 32 samples: the running sum of magnitudes shifted right by 5. The sum changes only on a sample strobe. A sample of -32768 has magnitude 32768.
- R4: Timing of an event starts only when the average is strictly greater than the loud level. An average equal to the loud level starts nothing.
- R5: Timing ends when the average falls strictly below 64. The event is then judged, and a duration of 0 to 3 ticks adds one to the count.
- R6: An event lasting 4 or more ticks is not counted. The 4-bit timer saturates at 15 and does not wrap, so very long events are never counted.
- R7: The timer advances once per rising edge of the slow tick input, after a two-flop synchroniser. Holding the tick input high adds only one tick.
- R8: A write loads the loud level from data bits 9:0. Bits 14:10 are ignored. Bit 15 set to 1 disables detection and freezes the count. A later write with bit 15 clear resumes detection.
- R9: If the loud level is below 64, then while the average lies above the loud level and below 64 the count increases once every 3 clock cycles.
- R10: The toggle bit inverts exactly when the count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | New audio sample strobe |
| smp_data_i | input | 16 | Signed audio sample |
| tick_raw_i | input | 1 | Slow asynchronous timing tick (about 10 Hz) |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 16 | Configuration word: bit 15 disables detection, bits 9:0 set the loud level |
| rd_data_o | output | 16 | Status word: {count[14:0], toggle} |

## Verification
Random events are driven with a random amplitude, a random sign and a random tick duration. Random level writes are mixed in, some with detection disabled. Each event therefore tests the amplitude-versus-level comparison and the duration window together.

Directed events separate the remaining cases:
- An amplitude equal to the level, against one just above it, tells a strict compare from a non-strict one.
- Durations of 0, 3, 4 and 17 ticks show the window edges and expose a timer that wraps instead of saturating.
- A tick held high for a long time separates edge detection from level sensing.
- A write with bits 14:10 set checks that only bits 9:0 reach the loud level.
- A level below the quiet constant with a steady mid-level input checks the rate of the repeated counting.

// File: rtl/clap_pkg.sv
package clap_pkg;
  typedef enum logic [1:0] {
    ST_ARM   = 2'd0,
    ST_TIME  = 2'd1,
    ST_JUDGE = 2'd2
  } clap_state_e;
endpackage

// File: rtl/clap_tick_sync.sv
module clap_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic tick_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign tick_o = sync_q[STAGES-1] & ~prev_q;

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/clap_averager.sv
module clap_averager #(
  parameter int SMP_W = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SMP_W-1:0] smp_i,
  output logic [SMP_W-1:0] avg_o
);
  localparam int SH    = $clog2(DEPTH);
  localparam int SUM_W = SMP_W + SH;

  logic [SMP_W-1:0] mag;
  logic [SMP_W-1:0] win_q [DEPTH];
  logic [SUM_W-1:0] sum_q;

  // magnitude of the signed sample; the most negative value maps to 2**(SMP_W-1)
  assign mag = smp_i[SMP_W-1] ? (~smp_i + 1'b1) : smp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q[0] <= '0;
    else if (valid_i) win_q[0] <= mag;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) win_q[g] <= '0;
      else if (valid_i) win_q[g] <= win_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_q <= '0;
    else if (valid_i) sum_q <= sum_q + SUM_W'(mag) - SUM_W'(win_q[DEPTH-1]);
  end

  assign avg_o = sum_q[SUM_W-1:SH];

  assert_sum_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(sum_q));
endmodule

// File: rtl/clap_dur_timer.sv
module clap_dur_timer #(
  parameter int TMR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [TMR_W-1:0] dur_o
);
  logic [TMR_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tmr_q <= '0;
    else if (clr_i) tmr_q <= '0;
    else if (run_i && tick_i && (tmr_q != '1)) tmr_q <= tmr_q + 1'b1;
  end

  assign dur_o = tmr_q;

  assert_tmr_saturates_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_q == '1) |=> ((tmr_q == '1) || (tmr_q == '0)));
  assert_tmr_on_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tmr_q != $past(tmr_q)) && (tmr_q != '0)) |-> $past(tick_i));
endmodule

// File: rtl/clap_cfg_reg.sv
module clap_cfg_reg #(
  parameter int WR_W     = 16,
  parameter int THR_W    = 10,
  parameter int DEF_LOUD = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WR_W-1:0]  wr_data_i,
  output logic [THR_W-1:0] loud_o,
  output logic             en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loud_o <= THR_W'(DEF_LOUD);
      en_o   <= 1'b1;
    end else if (wr_en_i) begin
      loud_o <= wr_data_i[THR_W-1:0];
      en_o   <= ~wr_data_i[WR_W-1];
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(loud_o) && $stable(en_o)));
endmodule

// File: rtl/clap_detect_fsm.sv
module clap_detect_fsm
  import clap_pkg::*;
#(
  parameter int SMP_W     = 16,
  parameter int THR_W     = 10,
  parameter int TMR_W     = 4,
  parameter int CNT_W     = 15,
  parameter int MAX_DUR   = 3,
  parameter int QUIET_LVL = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SMP_W-1:0] avg_i,
  input  logic [THR_W-1:0] loud_i,
  input  logic [TMR_W-1:0] dur_i,
  output logic             tmr_clr_o,
  output logic             tmr_run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tog_o
);
  localparam logic [SMP_W-1:0] QUIET = SMP_W'(QUIET_LVL);
  localparam logic [TMR_W-1:0] DMAX  = TMR_W'(MAX_DUR);

  clap_state_e state_q, state_d;
  logic        is_loud, is_quiet, hit;

  assign is_loud  = avg_i > SMP_W'(loud_i);
  assign is_quiet = avg_i < QUIET;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARM:   if (en_i && is_loud) state_d = ST_TIME;
      ST_TIME:  if (!en_i) state_d = ST_ARM;
                else if (is_quiet) state_d = ST_JUDGE;
      ST_JUDGE: state_d = ST_ARM;
      default:  state_d = ST_ARM;
    endcase
  end

  assign tmr_clr_o = (state_q == ST_ARM);
  assign tmr_run_o = (state_q == ST_TIME);
  assign hit       = (state_q == ST_JUDGE) && en_i && (dur_i <= DMAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_ARM;
      cnt_o   <= '0;
      tog_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hit) begin
        cnt_o <= cnt_o + 1'b1;
        tog_o <= ~tog_o;
      end
    end
  end

  assert_judge_after_time_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_JUDGE) |-> ($past(state_q) == ST_TIME));
  assert_frozen_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> $stable(cnt_o));
endmodule

// File: rtl/clap_event_counter.sv
module clap_event_counter #(
  parameter int SMP_W       = 16,
  parameter int AVG_DEPTH   = 32,
  parameter int WR_W        = 16,
  parameter int THR_W       = 10,
  parameter int CNT_W       = 15,
  parameter int TMR_W       = 4,
  parameter int MAX_DUR     = 3,
  parameter int QUIET_LVL   = 64,
  parameter int DEF_LOUD    = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  input  logic             tick_raw_i,
  input  logic             wr_en_i,
  input  logic [WR_W-1:0]  wr_data_i,
  output logic [CNT_W:0]   rd_data_o
);
  logic [SMP_W-1:0] avg;
  logic [THR_W-1:0] loud;
  logic             en, tick, tmr_clr, tmr_run, tog;
  logic [TMR_W-1:0] dur;
  logic [CNT_W-1:0] cnt;

  clap_tick_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .raw_i(tick_raw_i), .tick_o(tick)
  );

  clap_averager #(.SMP_W(SMP_W), .DEPTH(AVG_DEPTH)) i_avg (
    .clk_i, .rst_ni, .valid_i(smp_valid_i), .smp_i(smp_data_i), .avg_o(avg)
  );

  clap_cfg_reg #(.WR_W(WR_W), .THR_W(THR_W), .DEF_LOUD(DEF_LOUD)) i_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .loud_o(loud), .en_o(en)
  );

  clap_dur_timer #(.TMR_W(TMR_W)) i_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .run_i(tmr_run), .tick_i(tick), .dur_o(dur)
  );

  clap_detect_fsm #(
    .SMP_W(SMP_W), .THR_W(THR_W), .TMR_W(TMR_W), .CNT_W(CNT_W),
    .MAX_DUR(MAX_DUR), .QUIET_LVL(QUIET_LVL)
  ) i_fsm (
    .clk_i, .rst_ni, .en_i(en), .avg_i(avg), .loud_i(loud), .dur_i(dur),
    .tmr_clr_o(tmr_clr), .tmr_run_o(tmr_run), .cnt_o(cnt), .tog_o(tog)
  );

  assign rd_data_o = {cnt, tog};

  assert_toggle_tracks_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt)) |-> (tog != $past(tog)));
  assert_count_steps_by_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/test_clap_event_counter.sv
module test_clap_event_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic        tick_raw = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int exp_cnt = 0;
  bit exp_tog = 0;
  int cur_thr = 256;
  bit cur_en = 1;

  always #2 clk = ~clk;

  clap_event_counter i_clap_event_counter (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .tick_raw_i(tick_raw), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data)
  );

  function automatic bit counts(int amp, int thr, int nt, bit en);
    return en && (amp > thr) && (nt <= 3);
  endfunction

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic check_word(string req);
    check(req, int'(rd_data), (exp_cnt % 32768) * 2 + int'(exp_tog));
  endtask

  task automatic push(int v);
    smp_data  = 16'(v);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic pulse_tick(int hi);
    tick_raw = 1'b1;
    repeat (hi) @(negedge clk);
    tick_raw = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_cfg(int val);
    wr_data = 16'(val);
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
    cur_thr = val & 1023;
    cur_en  = !val[15];
  endtask

  task automatic clap(int amp, bit neg, int nt, int long_hi);
    for (int i = 0; i < 32; i++) push(neg ? -amp : amp);
    repeat (8) @(negedge clk);
    for (int t = 0; t < nt; t++) pulse_tick((t == 0) ? long_hi : 6);
    for (int i = 0; i < 32; i++) push(0);
    repeat (8) @(negedge clk);
    if (counts(amp, cur_thr, nt, cur_en)) begin
      exp_cnt++;
      exp_tog = !exp_tog;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int c0, c1, amp, nt, r;
    bit neg;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    check("R1 reset word", int'(rd_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_word("R1 after release");

    // default level 256: equal does not start, one above does
    clap(256, 0, 1, 6); check_word("R4 equal to default level");
    clap(257, 0, 1, 6); check_word("R1 R4 above default level");
    check(       "R2 toggle in bit0", int'(rd_data[0]), 1);
    check(       "R2 count in bits15:1", int'(rd_data[15:1]), 1);
    // duration window and saturation
    clap(600, 0, 0, 6);  check_word("R5 zero ticks counts");
    clap(600, 1, 3, 6);  check_word("R5 three ticks counts");
    clap(600, 0, 4, 6);  check_word("R6 four ticks rejected");
    clap(600, 1, 17, 6); check_word("R6 saturation no wrap");
    // long high tick counts once; level sensing would give many ticks
    clap(600, 0, 3, 60); check_word("R7 held tick counts once");
    // most negative sample
    clap(32768, 1, 2, 6); check_word("R3 most negative sample");
    // bits 14:10 ignored
    write_cfg(16'h7C00 | 300);
    clap(300, 0, 1, 6); check_word("R8 level from bits9:0 equal");
    clap(301, 1, 1, 6); check_word("R8 level from bits9:0 above");
    // disable freezes count, re-enable resumes
    write_cfg(16'h8000 | 100);
    clap(800, 0, 1, 6); check_word("R8 disabled frozen");
    write_cfg(100);
    clap(800, 0, 1, 6); check_word("R8 re-enabled counts");

    // random events
    for (int k = 0; k < 40; k++) begin
      r = int'($urandom_range(0, 4));
      if (r == 0) begin
        int thr = int'($urandom_range(64, 1023));
        write_cfg(($urandom_range(0, 5) == 0) ? (thr | 16'h8000) : thr);
      end
      amp = int'($urandom_range(64, 1400));
      neg = 1'($urandom_range(0, 1));
      nt  = int'($urandom_range(0, 6));
      clap(amp, neg, nt, 6);
      check_word("R3 R5 R6 random event");
    end

    // level below quiet constant: steady mid-level input repeats counts
    write_cfg(10);
    for (int i = 0; i < 32; i++) push(((i % 2) == 0) ? 30 : -30);
    repeat (6) @(negedge clk);
    c0 = int'(rd_data[15:1]);
    repeat (60) @(negedge clk);
    c1 = int'(rd_data[15:1]);
    n_chk++;
    if ((c1 - c0) < 19 || (c1 - c0) > 21) begin
      n_bad++;
      $display("FAIL R9 rapid count: got %0d expected 20", c1 - c0);
    end
    check("R10 toggle parity", int'(rd_data[0]), int'(rd_data[1]) ^ int'(exp_tog ^ exp_cnt[0]));
    write_cfg(256);
    for (int i = 0; i < 32; i++) push(0);
    repeat (8) @(negedge clk);
    exp_cnt = int'(rd_data[15:1]);
    exp_tog = rd_data[0];
    clap(500, 0, 2, 6); check_word("R5 normal after rapid mode");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule